// File: doc/BRIEF.md
# Upper-Memory Bank Mapper

This block sits beside the CPU of an 8-bit machine with a 64 KB address space. For every access it decides whether the upper part of the map is served by ROM or by RAM. When ROM serves an access, it also says which of four ROM images backs it. It produces three things: a region select, a ROM image number, and a RAM address trimmed by a static size mask. The memory arrays themselves live elsewhere. This block only steers them.

Software changes the banking by writing to dedicated addresses. The data written is never examined.
- One address turns ROM on for the upper windows.
- A second address turns RAM on for the upper windows.
- Any write inside a 16-byte selector page chooses the low and high ROM images from the low address bits of that write.

The region and image outputs are combinational from the current access and the registered bank state. A bank-switch write therefore takes effect on the access that follows it. There is no data stream and no back-pressure: every access is decoded in the cycle it is presented.

Top module: `bank_map_ctrl`

## Requirements
- R1: After reset, ROM is on (`rom_on`=1) and both the low and high image selects are 0.
- R2: A write to 0xFF3E turns ROM on from the next access onward, whatever the data value.
- R3: A write to 0xFF3F turns RAM on (`rom_on`=0) from the next access onward, whatever the data value.
- R4: A write to any address 0xFDD0–0xFDDF does two things from the next access onward. The low image becomes address bits 1:0 and the high image becomes address bits 3:2. `rom_on` is unchanged.
- R5: With ROM on, a read of 0x8000–0xBFFF gives region LOROM (code 2) and `rom_img` equal to the low image.
- R6: With ROM on, a read of 0xC000–0xFFFF outside page 0xFC gives region HIROM (code 3) and `rom_img` equal to the high image.
- R7: With ROM on, a read of 0xFC00–0xFCFF gives region HIROM and `rom_img` 0, whatever the high image is.
- R8: With RAM on, a read of 0x8000–0xFFFF gives region RAM (code 1).
- R9: A read of 0x0000–0x7FFF gives region RAM in either mode.
- R10: A write gives region RAM in either mode. The exceptions are the two mode addresses and the selector page, which give region NONE (code 0). When `wr` and `rd` are both high, the access is treated as a write.
- R11: `ram_addr` always equals `addr` ANDed with `ram_mask`.
- R12: With neither `rd` nor `wr` high, the region is NONE and `rom_img` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 16 | CPU address |
| wdata | input | 8 | CPU write data (never decoded) |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe |
| ram_mask | input | 16 | Static RAM size mask (0x3FFF, 0x7FFF or 0xFFFF) |
| region | output | 2 | 0 NONE, 1 RAM, 2 LOROM, 3 HIROM |
| rom_img | output | 2 | ROM image number for the access |
| ram_addr | output | 16 | Masked RAM address |
| rom_on | output | 1 | Read-only mode flag, 1 when ROM serves upper windows |

## Verification
Two things can fall in the same cycle: a bank-switch write, and the decode of that same access. The bench provokes this by issuing each switch write while the sweep is running. It then judges two points. First, the write's own cycle still decodes with the old state and reports NONE. Second, the very next read sees the new mode or image. A second overlap is a cycle with both strobes high. In that case the bench expects write decoding, and it expects a control address in that cycle to still switch the bank.

// File: rtl/bmc_pkg.sv
package bmc_pkg;
  typedef enum logic [1:0] {
    REG_NONE  = 2'd0,
    REG_RAM   = 2'd1,
    REG_LOROM = 2'd2,
    REG_HIROM = 2'd3
  } region_e;
endpackage

// File: rtl/bmc_switch_regs.sv
module bmc_switch_regs #(
  parameter int AW = 16,
  parameter int IW = 2,
  parameter logic [AW-1:0] ROM_ADDR = 16'hFF3E,
  parameter logic [AW-1:0] RAM_ADDR = 16'hFF3F,
  parameter logic [AW-5:0] SEL_PAGE = 12'hFDD
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          wr,
  output logic          rom_on,
  output logic [IW-1:0] lo_img,
  output logic [IW-1:0] hi_img
);
  logic hit_rom, hit_ram, hit_sel;

  assign hit_rom = wr && (addr == ROM_ADDR);
  assign hit_ram = wr && (addr == RAM_ADDR);
  assign hit_sel = wr && (addr[AW-1:4] == SEL_PAGE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rom_on <= 1'b1;
      lo_img <= '0;
      hi_img <= '0;
    end else begin
      if (hit_rom)      rom_on <= 1'b1;
      else if (hit_ram) rom_on <= 1'b0;
      if (hit_sel) begin
        lo_img <= addr[IW-1:0];
        hi_img <= addr[2*IW-1:IW];
      end
    end
  end
endmodule

// File: rtl/bmc_region_decode.sv
module bmc_region_decode
  import bmc_pkg::*;
#(
  parameter int AW = 16,
  parameter int IW = 2,
  parameter logic [AW-1:0] ROM_ADDR = 16'hFF3E,
  parameter logic [AW-1:0] RAM_ADDR = 16'hFF3F,
  parameter logic [AW-5:0] SEL_PAGE = 12'hFDD,
  parameter logic [7:0]    FIX_PAGE = 8'hFC
) (
  input  logic [AW-1:0] addr,
  input  logic          rd,
  input  logic          wr,
  input  logic          rom_on,
  input  logic [IW-1:0] lo_img,
  input  logic [IW-1:0] hi_img,
  output region_e       region,
  output logic [IW-1:0] rom_img
);
  logic is_ctl, upper, hi_half, fixed_pg;

  assign is_ctl   = (addr == ROM_ADDR) || (addr == RAM_ADDR) || (addr[AW-1:4] == SEL_PAGE);
  assign upper    = addr[AW-1];
  assign hi_half  = addr[AW-2];
  assign fixed_pg = (addr[AW-1:AW-8] == FIX_PAGE);

  always_comb begin
    region  = REG_NONE;
    rom_img = '0;
    if (wr) begin
      region = is_ctl ? REG_NONE : REG_RAM;
    end else if (rd) begin
      if (!upper || !rom_on) begin
        region = REG_RAM;
      end else if (!hi_half) begin
        region  = REG_LOROM;
        rom_img = lo_img;
      end else begin
        region  = REG_HIROM;
        rom_img = fixed_pg ? '0 : hi_img;
      end
    end
  end
endmodule

// File: rtl/bank_map_ctrl.sv
module bank_map_ctrl
  import bmc_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8,
  parameter int IW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic          rd,
  input  logic          wr,
  input  logic [AW-1:0] ram_mask,
  output logic [1:0]    region,
  output logic [IW-1:0] rom_img,
  output logic [AW-1:0] ram_addr,
  output logic          rom_on
);
  logic [IW-1:0] lo_img, hi_img;
  region_e       reg_dec;
  logic          unused_data;

  assign unused_data = ^wdata;

  bmc_switch_regs #(.AW(AW), .IW(IW)) u_regs (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr(wr),
    .rom_on(rom_on), .lo_img(lo_img), .hi_img(hi_img)
  );

  bmc_region_decode #(.AW(AW), .IW(IW)) u_dec (
    .addr(addr), .rd(rd), .wr(wr), .rom_on(rom_on),
    .lo_img(lo_img), .hi_img(hi_img),
    .region(reg_dec), .rom_img(rom_img)
  );

  assign region   = reg_dec;
  assign ram_addr = addr & ram_mask;
endmodule

// File: rtl/bmc_chk.sv
module bmc_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] addr,
  input logic        rd,
  input logic        wr,
  input logic [15:0] ram_mask,
  input logic [1:0]  region,
  input logic [1:0]  rom_img,
  input logic [15:0] ram_addr,
  input logic        rom_on
);
  // R2
  rom_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == 16'hFF3E) |=> rom_on);
  // R3
  ram_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == 16'hFF3F) |=> !rom_on);
  // R4
  img_page_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr[15:4] == 12'hFDD) |=> $stable(rom_on));
  // R7
  fixed_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && !wr && rom_on && addr[15:8] == 8'hFC) |-> (region == 2'd3 && rom_img == 2'd0));
  // R8
  ram_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && !wr && !rom_on) |-> region == 2'd1);
  // R11
  mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_addr & ~ram_mask) == 16'h0000);
  // R12
  idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd && !wr) |-> (region == 2'd0 && rom_img == 2'd0));
endmodule

bind bank_map_ctrl bmc_chk u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .rd(rd), .wr(wr),
  .ram_mask(ram_mask), .region(region), .rom_img(rom_img),
  .ram_addr(ram_addr), .rom_on(rom_on)
);

// File: tb/bank_map_ctrl_tb.sv
module bank_map_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic        rd = 1'b0, wr = 1'b0;
  logic [15:0] ram_mask = 16'hFFFF;
  logic [1:0]  region, rom_img;
  logic [15:0] ram_addr;
  logic        rom_on;
  int total = 0, bad = 0;
  bit m_rom;
  logic [1:0] m_lo, m_hi;

  always #4 clk = ~clk;

  bank_map_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .rd(rd), .wr(wr),
    .ram_mask(ram_mask), .region(region), .rom_img(rom_img),
    .ram_addr(ram_addr), .rom_on(rom_on)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h addr=%04h", req, act, exp, addr);
    end
  endtask

  function automatic int exp_reg(input logic [15:0] a, input bit r, input bit w);
    if (w) return (a == 16'hFF3E || a == 16'hFF3F || a[15:4] == 12'hFDD) ? 0 : 1;
    if (!r) return 0;
    if (a < 16'h8000 || !m_rom) return 1;
    if (a < 16'hC000) return 2;
    return 3;
  endfunction

  function automatic int exp_img(input logic [15:0] a, input bit r, input bit w);
    int g;
    g = exp_reg(a, r, w);
    if (w || g < 2) return 0;
    if (g == 2) return m_lo;
    return (a[15:8] == 8'hFC) ? 0 : m_hi;
  endfunction

  // one access: drive at negedge, check before posedge
  task automatic access(input logic [15:0] a, input bit r, input bit w, input logic [7:0] d, input string req);
    @(negedge clk);
    addr = a; rd = r; wr = w; wdata = d;
    #2;
    chk(region == exp_reg(a, r, w), req, region, exp_reg(a, r, w));
    chk(rom_img == exp_img(a, r, w), req, rom_img, exp_img(a, r, w));
    chk(ram_addr == (a & ram_mask), "R11", ram_addr, a & ram_mask);
    if (w && a == 16'hFF3E) m_rom = 1;
    if (w && a == 16'hFF3F) m_rom = 0;
    if (w && a[15:4] == 12'hFDD) begin m_lo = a[1:0]; m_hi = a[3:2]; end
  endtask

  initial begin
    #(8 * 200000);
    bad++; total++;
    $display("FAIL watchdog act=0 exp=1");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    m_rom = 1; m_lo = 0; m_hi = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #2;
    chk(rom_on == 1'b1, "R1", rom_on, 1);
    access(16'h8000, 1, 0, 8'h00, "R1");
    access(16'hE000, 1, 0, 8'h00, "R1");
    access(16'h1234, 0, 0, 8'h00, "R12");
    // sweep modes, image pairs and addresses
    for (int m = 0; m < 2; m++) begin
      access(m ? 16'hFF3F : 16'hFF3E, 0, 1, 8'(m * 37), m ? "R3" : "R2");
      @(negedge clk); #2;
      chk(rom_on == (m == 0), m ? "R3" : "R2", rom_on, m == 0);
      for (int g = 0; g < 16; g++) begin
        access(16'hFDD0 | 16'(g), 0, 1, 8'hA5, "R4");
        @(negedge clk); #2;
        chk(rom_on == (m == 0), "R4", rom_on, m == 0);
        for (int a = 0; a < 65536; a += 256) begin
          logic [15:0] aa;
          aa = 16'(a) | 16'(g * 3);
          access(aa, 1, 0, 8'h00, aa[15] ? (m ? "R8" : (aa[15:8] == 8'hFC ? "R7" :
                 (aa[14] ? "R6" : "R5"))) : "R9");
        end
      end
    end
    // writes in both modes, simultaneous strobes, data ignored
    for (int m = 0; m < 2; m++) begin
      access(m ? 16'hFF3E : 16'hFF3F, 1, 1, 8'hFF, "R10");
      for (int a = 0; a < 65536; a += 512) access(16'(a) | 16'h0011, m[0], 1, 8'h5A, "R10");
      access(16'hFF3E, 0, 1, 8'h00, "R10");
      access(16'hFF3F, 0, 1, 8'h3C, "R10");
      access(16'hFDD9, 0, 1, 8'h00, "R10");
    end
    // mask sweep
    for (int k = 0; k < 3; k++) begin
      ram_mask = (k == 0) ? 16'h3FFF : (k == 1) ? 16'h7FFF : 16'hFFFF;
      for (int a = 0; a < 65536; a += 1024) access(16'(a) ^ 16'h0155, 1, 0, 8'h00, "R11");
    end
    // idle after switching
    access(16'hFF3E, 0, 1, 8'h00, "R2");
    access(16'hC123, 0, 0, 8'h00, "R12");
    access(16'hC123, 1, 0, 8'h00, "R6");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule